// File: doc/BRIEF.md
# Control-Word Command Sequencer

This block sits between a memory-module initialisation engine and the command/address path. Each entry names one configuration word to program on a registered module: either a word in the register chip or a word in a data buffer. The entry also carries the value, the word number, a function-space number and a settle time in cycles. The block packs value and word number into a 14-bit address pattern whose layout depends on the word kind. It issues that pattern as a single-cycle command strobe and then holds off further commands until the settle time has passed.

Data-buffer words are spread over several function spaces. The block remembers which space the buffer currently points at, starting at 0 after reset. It inserts a space-select write when a buffer entry lives elsewhere. An entry can also ask for the pointer to be returned to space 0 once it completes. A select write is a normal 4-bit buffer write of word 7 with the target space as its value, followed by a fixed, parameterised settle time. A done pulse marks the end of an entry flagged as last, after its settle time and after any return to space 0.

Top module: `ctlword_seq`

## Requirements
- R1: After reset the block has no strobe, no done pulse, an all-zero address and ready high, and the remembered buffer space is 0.
- R2: For kind code 0 (4-bit buffer) and kind code 2 (4-bit register), address bits 3:0 carry the low value nibble and bits 7:4 carry the low four word-number bits. Value bits 7:4 and word bit 4 have no effect.
- R3: For kind code 1 (8-bit buffer), address bits 7:0 carry the value and bits 11:8 the low four word-number bits.
- R4: For kind code 3 (8-bit register), address bits 7:0 carry the value and bits 12:8 the full five-bit word number.
- R5: Address bit 12 is 1 for every buffer command, including select writes. For 4-bit register commands it is 0, and all address bits not named by R2 to R4 are 0.
- R6: A buffer entry whose space differs from the remembered space is preceded by a select write with address 0x1070 plus the space number. The remembered space then takes that number. Every accepted entry produces a strobe in the next cycle.
- R7: Register entries never cause a select write and leave the remembered space unchanged, whatever their space field holds.
- R8: The strobe lasts one cycle. After a command with settle time W (SEL_WAIT for select writes), the next strobe comes exactly max(W,1)+1 cycles later when the following command is already pending.
- R9: An entry with the return flag set is followed, after its settle time, by a select write to space 0 (address 0x1070). This happens even if the space is already 0, and the remembered space becomes 0.
- R10: For an entry with the last flag, done pulses for one cycle, max(W,1) cycles after the final strobe of that entry. That final strobe is the return select if one was requested, with W = SEL_WAIT. Ready is high in that cycle.
- R11: An entry with value zero is still issued as a normal command.
- R12: A 4-bit buffer write of word 7 in space 0 sets the remembered space to the low value nibble.
- R13: Ready is low while a strobe is driven and until the settle counter of the current command is at its last cycle. The address is all zero whenever no strobe is driven.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Entry offered |
| in_ready | output | 1 | Entry accepted when high together with in_valid |
| in_kind | input | 2 | Word kind: 0 buffer 4-bit, 1 buffer 8-bit, 2 register 4-bit, 3 register 8-bit |
| in_space | input | 4 | Function space of a buffer word |
| in_word | input | 5 | Word number |
| in_data | input | 8 | Value to write |
| in_wait | input | WAIT_W | Settle cycles after this command |
| in_last | input | 1 | Entry ends a sequence |
| in_home | input | 1 | Return buffer space to 0 after this entry |
| cmd_stb | output | 1 | One-cycle command strobe |
| cmd_addr | output | 14 | Address pattern, valid with cmd_stb |
| done | output | 1 | One-cycle end-of-sequence pulse |

## Verification
The bench goes after the space-tracking corners. These are buffer entries that hop between spaces, register entries carrying a non-zero space field, and a word-7 write in space 0 that moves the pointer without a select. A design that missed any of these would issue an extra select or skip one, and every later address would then be off by one command. Zero-valued writes, zero and large settle times, and junk in the ignored upper value and word bits are also covered. A wrong gap shows up as a strobe one cycle early or late. A field mask error shows up as a corrupted address bit, most visibly bit 12. A misplaced done pulse is caught against the last strobe plus its settle time.

// File: rtl/ctlword_pkg.sv
package ctlword_pkg;

    localparam int ADDR_W      = 14;
    localparam int SPACE_W     = 4;
    localparam int WORD_W      = 5;
    localparam int DATA_W      = 8;
    localparam int NIB_W       = 4;
    localparam int BUF_BIT     = 12;
    localparam int SEL_WORD    = 7;

    typedef enum logic [1:0] {
        CW_BUF4 = 2'd0,
        CW_BUF8 = 2'd1,
        CW_REG4 = 2'd2,
        CW_REG8 = 2'd3
    } cw_kind_e;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_SEL,
        SQ_SEL_WAIT,
        SQ_ENT,
        SQ_ENT_WAIT,
        SQ_HOME,
        SQ_HOME_WAIT
    } sq_state_e;

    typedef struct packed {
        cw_kind_e              kind;
        logic [SPACE_W-1:0]    space;
        logic [WORD_W-1:0]     word;
        logic [DATA_W-1:0]     data;
        logic                  last;
        logic                  home;
    } cw_entry_t;

    function automatic logic is_buffer(cw_kind_e k);
        return (k == CW_BUF4) || (k == CW_BUF8);
    endfunction

endpackage

// File: rtl/ctlword_enc.sv
module ctlword_enc
    import ctlword_pkg::*;
(
    input  cw_kind_e            kind,
    input  logic [WORD_W-1:0]   word,
    input  logic [DATA_W-1:0]   data,
    output logic [ADDR_W-1:0]   addr
);

    localparam int WIDE_LO = DATA_W;
    localparam int NARROW_LO = NIB_W;

    always_comb begin
        addr = '0;
        case (kind)
            CW_BUF4: begin
                addr[NARROW_LO-1:0]              = data[NIB_W-1:0];
                addr[NARROW_LO +: NIB_W]         = word[NIB_W-1:0];
                addr[BUF_BIT]                    = 1'b1;
            end
            CW_BUF8: begin
                addr[WIDE_LO-1:0]                = data;
                addr[WIDE_LO +: NIB_W]           = word[NIB_W-1:0];
                addr[BUF_BIT]                    = 1'b1;
            end
            CW_REG4: begin
                addr[NARROW_LO-1:0]              = data[NIB_W-1:0];
                addr[NARROW_LO +: NIB_W]         = word[NIB_W-1:0];
            end
            default: begin
                addr[WIDE_LO-1:0]                = data;
                addr[WIDE_LO +: WORD_W]          = word;
            end
        endcase
    end

endmodule

// File: rtl/ctlword_timer.sv
module ctlword_timer #(
    parameter int WAIT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WAIT_W-1:0] load_val,
    output logic              near_end
);

    logic [WAIT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign near_end = (cnt_q <= WAIT_W'(1));

endmodule

// File: rtl/ctlword_seq.sv
module ctlword_seq
    import ctlword_pkg::*;
#(
    parameter int WAIT_W   = 16,
    parameter int SEL_WAIT = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [1:0]           in_kind,
    input  logic [3:0]           in_space,
    input  logic [4:0]           in_word,
    input  logic [7:0]           in_data,
    input  logic [WAIT_W-1:0]    in_wait,
    input  logic                 in_last,
    input  logic                 in_home,
    output logic                 cmd_stb,
    output logic [13:0]          cmd_addr,
    output logic                 done
);

    localparam logic [WAIT_W-1:0] SEL_SETTLE = WAIT_W'(SEL_WAIT);
    localparam logic [WORD_W-1:0] SEL_NUM    = WORD_W'(SEL_WORD);

    typedef struct packed {
        sq_state_e            st;
        cw_entry_t            ent;
        logic [WAIT_W-1:0]    settle;
        logic [SPACE_W-1:0]   cur_space;
    } seq_t;

    seq_t seq_d, seq_q;

    cw_entry_t           in_ent;
    cw_kind_e            enc_kind;
    logic [WORD_W-1:0]   enc_word;
    logic [DATA_W-1:0]   enc_data;
    logic [ADDR_W-1:0]   enc_addr;
    logic                tmr_load;
    logic [WAIT_W-1:0]   tmr_val;
    logic                tmr_end;
    logic                free;
    logic                stb;
    logic                done_c;

    always_comb begin
        in_ent.kind  = cw_kind_e'(in_kind);
        in_ent.space = in_space;
        in_ent.word  = in_word;
        in_ent.data  = in_data;
        in_ent.last  = in_last;
        in_ent.home  = in_home;
    end

    always_comb begin
        seq_d    = seq_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        enc_kind = CW_BUF4;
        enc_word = SEL_NUM;
        enc_data = '0;
        free     = 1'b0;
        stb      = 1'b0;
        done_c   = 1'b0;

        case (seq_q.st)
            SQ_IDLE: begin
                free = 1'b1;
            end
            SQ_SEL: begin
                stb             = 1'b1;
                enc_data        = DATA_W'(seq_q.ent.space);
                tmr_load        = 1'b1;
                tmr_val         = SEL_SETTLE;
                seq_d.cur_space = seq_q.ent.space;
                seq_d.st        = SQ_SEL_WAIT;
            end
            SQ_SEL_WAIT: begin
                if (tmr_end) begin
                    seq_d.st = SQ_ENT;
                end
            end
            SQ_ENT: begin
                stb      = 1'b1;
                enc_kind = seq_q.ent.kind;
                enc_word = seq_q.ent.word;
                enc_data = seq_q.ent.data;
                tmr_load = 1'b1;
                tmr_val  = seq_q.settle;
                if (seq_q.ent.kind == CW_BUF4 && seq_q.ent.space == '0 &&
                    seq_q.ent.word[NIB_W-1:0] == SEL_NUM[NIB_W-1:0]) begin
                    seq_d.cur_space = seq_q.ent.data[SPACE_W-1:0];
                end
                seq_d.st = SQ_ENT_WAIT;
            end
            SQ_ENT_WAIT: begin
                if (tmr_end) begin
                    if (seq_q.ent.home) begin
                        seq_d.st = SQ_HOME;
                    end else begin
                        free     = 1'b1;
                        done_c   = seq_q.ent.last;
                        seq_d.st = SQ_IDLE;
                    end
                end
            end
            SQ_HOME: begin
                stb             = 1'b1;
                tmr_load        = 1'b1;
                tmr_val         = SEL_SETTLE;
                seq_d.cur_space = '0;
                seq_d.st        = SQ_HOME_WAIT;
            end
            SQ_HOME_WAIT: begin
                if (tmr_end) begin
                    free     = 1'b1;
                    done_c   = seq_q.ent.last;
                    seq_d.st = SQ_IDLE;
                end
            end
            default: begin
                seq_d.st = SQ_IDLE;
            end
        endcase

        if (free && in_valid) begin
            seq_d.ent    = in_ent;
            seq_d.settle = in_wait;
            if (is_buffer(in_ent.kind) && in_ent.space != seq_q.cur_space) begin
                seq_d.st = SQ_SEL;
            end else begin
                seq_d.st = SQ_ENT;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '{st: SQ_IDLE, ent: '0, settle: '0, cur_space: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    ctlword_enc u_enc (
        .kind (enc_kind),
        .word (enc_word),
        .data (enc_data),
        .addr (enc_addr)
    );

    ctlword_timer #(.WAIT_W(WAIT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .near_end (tmr_end)
    );

    assign in_ready = free;
    assign cmd_stb  = stb;
    assign cmd_addr = stb ? enc_addr : '0;
    assign done     = done_c;

endmodule

// File: rtl/ctlword_seq_chk.sv
module ctlword_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic        in_ready,
    input logic [1:0]  in_kind,
    input logic        cmd_stb,
    input logic [13:0] cmd_addr,
    input logic        done
);

    // R8
    stb_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_stb |=> !cmd_stb);

    // R13
    busy_on_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_stb |-> !in_ready);

    // R13
    addr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_stb |-> (cmd_addr == 14'd0));

    // R10
    done_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (in_ready && !cmd_stb));

    // R6
    accept_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> cmd_stb);

    // R5
    buf_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !in_kind[1]) |=> cmd_addr[12]);

    // R5
    reg4_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_kind == 2'd2) |=> !cmd_addr[12]);

endmodule

bind ctlword_seq ctlword_seq_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_kind  (in_kind),
    .cmd_stb  (cmd_stb),
    .cmd_addr (cmd_addr),
    .done     (done)
);

// File: tb/ctlword_seq_bench.sv
module ctlword_seq_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WAIT_W     = 16;
    localparam int SEL_WAIT   = 4;
    localparam int MAX_CYC    = 150000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [1:0]        in_kind = '0;
    logic [3:0]        in_space = '0;
    logic [4:0]        in_word = '0;
    logic [7:0]        in_data = '0;
    logic [WAIT_W-1:0] in_wait = '0;
    logic              in_last = 1'b0;
    logic              in_home = 1'b0;
    logic              cmd_stb;
    logic [13:0]       cmd_addr;
    logic              done;

    always #(CLK_PERIOD/2) clk = ~clk;

    ctlword_seq #(.WAIT_W(WAIT_W), .SEL_WAIT(SEL_WAIT)) u_ctlword_seq (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_kind(in_kind), .in_space(in_space), .in_word(in_word),
        .in_data(in_data), .in_wait(in_wait), .in_last(in_last),
        .in_home(in_home), .cmd_stb(cmd_stb), .cmd_addr(cmd_addr), .done(done)
    );

    int checks_n = 0;
    int fails_n  = 0;
    int cyc      = 0;
    int last_stb = 0;
    int done_cnt = 0;
    int seq_cnt  = 0;
    int stray    = 0;
    int exp_done_delta = 0;
    bit finished = 0;

    logic [13:0] q_addr[$];
    int          q_gap[$];
    string       q_tag[$];

    int  m_space;
    int  m_prev_wait;
    bit  m_first;

    function automatic int at_least_one(int w);
        return (w < 1) ? 1 : w;
    endfunction

    // Expected address built from the field rules R2, R3, R4, R5
    function automatic logic [13:0] exp_enc(int kind, int word, int data);
        int a;
        case (kind)
            0: a = 4096 + (word % 16) * 16 + (data % 16);
            1: a = 4096 + (word % 16) * 256 + (data % 256);
            2: a = (word % 16) * 16 + (data % 16);
            default: a = (word % 32) * 256 + (data % 256);
        endcase
        return 14'(a);
    endfunction

    function automatic void push_exp(logic [13:0] a, string tag, int w);
        q_addr.push_back(a);
        q_gap.push_back(m_first ? -1 : at_least_one(m_prev_wait) + 1);
        q_tag.push_back(tag);
        m_prev_wait = w;
        m_first = 0;
    endfunction

    task automatic send(int kind, int space, int word, int data, int w, bit last, bit home);
        string tag;
        if (kind < 2 && space != m_space) begin
            push_exp(exp_enc(0, 7, space), "R6", SEL_WAIT);
            m_space = space;
        end
        if (data == 0) tag = "R11";
        else if (kind == 0 && space == 0 && (word % 16) == 7) tag = "R12";
        else if (kind >= 2 && space != 0) tag = "R7";
        else if (kind == 1) tag = "R3";
        else if (kind == 3) tag = "R4";
        else tag = "R2";
        push_exp(exp_enc(kind, word, data), tag, w);
        if (kind == 0 && space == 0 && (word % 16) == 7) m_space = data % 16;
        if (home) begin
            push_exp(exp_enc(0, 7, 0), "R9", SEL_WAIT);
            m_space = 0;
        end
        if (last) exp_done_delta = at_least_one(m_prev_wait);

        @(negedge clk);
        in_valid = 1'b1;
        in_kind  = 2'(kind);
        in_space = 4'(space);
        in_word  = 5'(word);
        in_data  = 8'(data);
        in_wait  = WAIT_W'(w);
        in_last  = last;
        in_home  = home;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        if (last) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    task automatic begin_seq();
        m_first = 1;
        seq_cnt++;
    endtask

    task automatic end_seq();
        while (done_cnt < seq_cnt) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            cyc++;
            if (cmd_stb) begin
                checks_n++;
                if (q_addr.size() == 0) begin
                    fails_n++;
                    $display("FAIL R6 unexpected strobe addr=%h expected none", cmd_addr);
                end else begin
                    logic [13:0] ea;
                    int eg;
                    string et;
                    ea = q_addr.pop_front();
                    eg = q_gap.pop_front();
                    et = q_tag.pop_front();
                    if (cmd_addr != ea) begin
                        fails_n++;
                        if (cmd_addr[12] != ea[12])
                            $display("FAIL R5 %s addr=%h expected %h", et, cmd_addr, ea);
                        else
                            $display("FAIL %s addr=%h expected %h", et, cmd_addr, ea);
                    end
                    if (eg >= 0) begin
                        checks_n++;
                        if (cyc - last_stb != eg) begin
                            fails_n++;
                            $display("FAIL R8 strobe gap=%0d expected %0d", cyc - last_stb, eg);
                        end
                    end
                end
                checks_n++;
                if (in_ready) begin
                    fails_n++;
                    $display("FAIL R13 ready=%b during strobe expected 0", in_ready);
                end
                last_stb = cyc;
            end else if (cmd_addr != 14'd0) begin
                stray++;
            end
            if (done) begin
                done_cnt++;
                checks_n++;
                if (cyc - last_stb != exp_done_delta) begin
                    fails_n++;
                    $display("FAIL R10 done delay=%0d expected %0d", cyc - last_stb, exp_done_delta);
                end
            end
        end
    end

    task automatic summary();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks_n, fails_n);
        $finish;
    endtask

    initial begin
        repeat (MAX_CYC) @(posedge clk);
        checks_n++;
        fails_n++;
        $display("FAIL watchdog expired at %0d cycles, expected completion", MAX_CYC);
        summary();
    end

    initial begin
        void'($urandom(32'd20240611));
        m_space = 0;
        m_prev_wait = 0;
        m_first = 1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        checks_n++;
        if (!(in_ready === 1'b1 && cmd_stb === 1'b0 && done === 1'b0 && cmd_addr === 14'd0)) begin
            fails_n++;
            $display("FAIL R1 ready=%b stb=%b done=%b addr=%h expected 1 0 0 0000",
                     in_ready, cmd_stb, done, cmd_addr);
        end

        // R1/R2: space 0 buffer write needs no select after reset
        begin_seq();
        send(0, 0, 3, 8'hFA, 5, 1, 0);
        end_seq();

        // R6 R3 R11 R7 R4 R12 R9 directed sequence
        begin_seq();
        send(1, 6, 4, 8'h5C, 3, 0, 0);
        send(1, 5, 6, 8'h00, 2, 0, 0);
        send(2, 9, 5'h12, 8'hF3, 0, 0, 0);
        send(3, 0, 5'h1B, 8'hA5, 4, 0, 0);
        send(0, 0, 7, 8'h03, 1, 0, 0);
        send(0, 3, 1, 8'h02, 2, 0, 0);
        send(2, 0, 4, 8'h07, 300, 0, 0);
        send(0, 3, 9, 8'h01, 0, 1, 1);
        end_seq();

        // R9 return with space already 0, R8 zero waits back to back
        begin_seq();
        send(3, 15, 31, 8'hFF, 0, 0, 0);
        send(0, 0, 2, 8'h00, 0, 1, 1);
        end_seq();

        for (int s = 0; s < 25; s++) begin
            int n;
            n = 1 + int'($urandom % 8);
            begin_seq();
            for (int i = 0; i < n; i++) begin
                int k, sp, pick;
                bit lst, hm;
                k = int'($urandom % 4);
                pick = int'($urandom % 4);
                sp = (pick == 0) ? 0 : (pick == 1) ? 5 : (pick == 2) ? 6 : int'($urandom % 16);
                lst = (i == n - 1);
                hm = lst ? bit'($urandom % 2) : ($urandom % 8 == 0);
                send(k, sp, int'($urandom % 32), int'($urandom % 256),
                     int'($urandom % 13), lst, hm);
            end
            end_seq();
        end

        checks_n++;
        if (q_addr.size() != 0) begin
            fails_n++;
            $display("FAIL R6 missing strobes=%0d expected 0", q_addr.size());
        end
        checks_n++;
        if (stray != 0) begin
            fails_n++;
            $display("FAIL R13 nonzero idle address cycles=%0d expected 0", stray);
        end
        checks_n++;
        if (done_cnt != seq_cnt) begin
            fails_n++;
            $display("FAIL R10 done pulses=%0d expected %0d", done_cnt, seq_cnt);
        end
        summary();
    end

endmodule